// File: doc/BRIEF.md
# Latched Multi-Record Serial Readout Port

This block is the device-side readout path of a metering core. The core presents several 32-bit result records on parallel inputs. A host captures a consistent snapshot of all of them into transmit latches with one wide pulse on a sync line while chip select is idle. It then asserts chip select and clocks the snapshot out on a single serial data line. A short sync pulse during the transfer, or a latch pulse that is simply held past the assertion of chip select, puts the bit pointer back to the start of the stream.

Each record leaves as four bytes, lowest byte first and most significant bit first inside each byte. The records follow one another with no gap. The top nibble of every record holds a check code made upstream, and it is passed through untouched. A one-cycle precharge strobe, given before a transaction, starts that transaction from the record in the middle of the set and wraps around to the first. Serial clock, sync and chip select are synchronised into the measurement clock domain. All edge detection is done in that domain.

Top module: `rec_readout_port`

## Requirements
- R1: While chip select is idle, a sync pulse copies all NREC records from `rec_data` into the transmit latches in the same cycle.
- R2: A latch pulse must stay high for more than LATCH_MIN (default 2) measurement clock cycles after synchronisation. A pulse of LATCH_MIN cycles or fewer leaves the latches unchanged.
- R3: While chip select is active, sync high sets the bit pointer to zero and does not re-latch. A pulse held from the idle phase into the active phase has the same effect.
- R4: Each falling serial clock edge during an active transfer advances the stream by one bit. A record takes REC_W (32) clocks, and records follow back to back.
- R5: Stream bit k of a record (k = 0 to 31) carries record bit 8*(k/8) + 7 - (k mod 8). This means least significant byte first, and MSB first within each byte.
- R6: All 32 record bits are sent unchanged, including the check nibble in bits 31:28.
- R7: Without precharge, the stream sends the records in index order 0, 1, …, NREC-1.
- R8: A one-cycle `precharge` strobe while chip select is idle makes the next transaction send indices NREC/2 … NREC-1, then 0 … NREC/2-1. The rotation is cleared when chip select is deasserted.
- R9: After the last bit of the last record, `sdo` stays 0 until chip select is released.
- R10: Deasserting chip select aborts a transfer at any bit. `sdo` becomes 0, and the next transaction starts at bit 0 of the first record.
- R11: After reset, `sdo` is 0 and every transmit latch holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sync_in | input | 1 | Latch / pointer-reset line, active high, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| precharge | input | 1 | One-cycle strobe in the clk domain requesting rotated order |
| rec_data | input | NREC*REC_W | Live records, record i at bits [i*REC_W +: REC_W] |
| sdo | output | 1 | Serial data, changes after falling `sclk`, sampled by host on rising |

## Verification
The assertions assume that every asynchronous input holds each level for several measurement clock cycles. They also assume that serial clock edges are far enough apart for each one to be seen as a single synchronised edge, and that `precharge` is never given in the cycle in which chip select is released. The stimulus keeps every serial clock phase and every settle interval at six measurement clocks. It drives all inputs half a cycle away from the active edge, and it gives precharge only during long idle gaps. The pulse-width boundary is probed with pulses of exactly LATCH_MIN and LATCH_MIN+1 cycles.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

  // Position inside a record of the k-th bit sent: bytes ascend, bits descend.
  function automatic int unsigned rrp_bit_pos(int unsigned k);
    return (k / 8) * 8 + 7 - (k % 8);
  endfunction

  // Record index sent in a given slot, with optional half rotation.
  function automatic int unsigned rrp_slot_rec(int unsigned slot, logic rot,
                                               int unsigned nrec);
    return rot ? (slot + nrec / 2) % nrec : slot;
  endfunction

endpackage

// File: rtl/rrp_sync2.sv
module rrp_sync2 #(
  parameter int  W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rrp_latch_ctrl.sv
module rrp_latch_ctrl #(
  parameter int LATCH_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sync_s,
  output logic latch_fire
);
  localparam int HW = $clog2(LATCH_MIN + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!sync_s) begin
      hi_cnt <= '0;
    end else if (hi_cnt <= HW'(LATCH_MIN)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // Fires once, on the first high cycle beyond the minimum width.
  assign latch_fire = sync_s && !cs_act && (hi_cnt == HW'(LATCH_MIN));
endmodule

// File: rtl/rrp_record_bank.sv
module rrp_record_bank #(
  parameter int NREC  = 8,
  parameter int REC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  latch_fire,
  input  logic [NREC*REC_W-1:0] rec_data,
  output logic [NREC*REC_W-1:0] latched
);
  for (genvar r = 0; r < NREC; r++) begin : g_rec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latched[r*REC_W +: REC_W] <= '0;
      end else if (latch_fire) begin
        latched[r*REC_W +: REC_W] <= rec_data[r*REC_W +: REC_W];
      end
    end
  end
endmodule

// File: rtl/rrp_shift_engine.sv
module rrp_shift_engine
  import rrp_pkg::*;
#(
  parameter int NREC  = 8,
  parameter int REC_W = 32,
  parameter int TOTAL = NREC * REC_W,
  parameter int CW    = $clog2(TOTAL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_act,
  input  logic                  sync_s,
  input  logic                  sclk_fall,
  input  logic                  precharge,
  input  logic [NREC*REC_W-1:0] latched,
  output logic [CW-1:0]         bit_cnt,
  output logic                  rot_flag,
  output logic                  sdo
);
  localparam int LW = $clog2(TOTAL);

  logic          cs_act_q;
  logic          cs_release;
  logic [LW-1:0] idx;

  assign cs_release = cs_act_q && !cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_act_q <= 1'b0;
      rot_flag <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      cs_act_q <= cs_act;
      if (cs_release) begin
        rot_flag <= 1'b0;
      end else if (precharge && !cs_act) begin
        rot_flag <= 1'b1;
      end
      if (!cs_act || sync_s) begin
        bit_cnt <= '0;
      end else if (sclk_fall && (bit_cnt < CW'(TOTAL))) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    int unsigned slot;
    int unsigned k;
    int unsigned rec;
    slot = int'(bit_cnt) / REC_W;
    k    = int'(bit_cnt) % REC_W;
    rec  = rrp_slot_rec(slot % NREC, rot_flag, NREC);
    idx  = LW'(rec * REC_W + rrp_bit_pos(k));
    sdo  = (cs_act && (bit_cnt < CW'(TOTAL))) ? latched[idx] : 1'b0;
  end
endmodule

// File: rtl/rec_readout_port.sv
module rec_readout_port #(
  parameter int NREC      = 8,
  parameter int REC_W     = 32,
  parameter int LATCH_MIN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sync_in,
  input  logic                  sclk,
  input  logic                  precharge,
  input  logic [NREC*REC_W-1:0] rec_data,
  output logic                  sdo
);
  localparam int TOTAL = NREC * REC_W;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [2:0]            sync_q;
  logic                  cs_act;
  logic                  sync_s;
  logic                  sclk_s;
  logic                  sclk_q;
  logic                  sclk_fall;
  logic                  latch_fire;
  logic                  rot_flag;
  logic [CW-1:0]         bit_cnt;
  logic [NREC*REC_W-1:0] latched;

  rrp_sync2 #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, sync_in, cs_n}),
    .q     (sync_q)
  );

  assign cs_act = !sync_q[0];
  assign sync_s = sync_q[1];
  assign sclk_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_fall = sclk_q && !sclk_s;

  rrp_latch_ctrl #(.LATCH_MIN(LATCH_MIN)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sync_s     (sync_s),
    .latch_fire (latch_fire)
  );

  rrp_record_bank #(.NREC(NREC), .REC_W(REC_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_fire (latch_fire),
    .rec_data   (rec_data),
    .latched    (latched)
  );

  rrp_shift_engine #(.NREC(NREC), .REC_W(REC_W), .TOTAL(TOTAL), .CW(CW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sync_s    (sync_s),
    .sclk_fall (sclk_fall),
    .precharge (precharge),
    .latched   (latched),
    .bit_cnt   (bit_cnt),
    .rot_flag  (rot_flag),
    .sdo       (sdo)
  );
endmodule

// File: rtl/rrp_checker.sv
module rrp_checker #(
  parameter int NREC      = 8,
  parameter int REC_W     = 32,
  parameter int LATCH_MIN = 2,
  parameter int CW        = $clog2(NREC * REC_W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          sync_s,
  input logic          sclk_fall,
  input logic          latch_fire,
  input logic          rot_flag,
  input logic [CW-1:0] bit_cnt,
  input logic          sdo
);
  localparam int TOTAL = NREC * REC_W;
  localparam int RW    = $clog2(LATCH_MIN + 2);

  logic [RW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hi_run <= '0;
    else if (!sync_s)                  hi_run <= '0;
    else if (hi_run <= RW'(LATCH_MIN)) hi_run <= hi_run + 1'b1;
  end

  assert_latch_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |-> !cs_act);

  assert_latch_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |-> (sync_s && hi_run >= RW'(LATCH_MIN)));

  assert_latch_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> !latch_fire);

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sync_s) |=> (bit_cnt == '0));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sync_s && sclk_fall && bit_cnt < CW'(TOTAL))
      |=> (bit_cnt == $past(bit_cnt) + 1'b1));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sync_s && !sclk_fall) |=> $stable(bit_cnt));

  assert_rot_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act) |=> !rot_flag);

  assert_tail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CW'(TOTAL)) |-> !sdo);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !sdo);
endmodule

bind rec_readout_port rrp_checker #(
  .NREC(NREC), .REC_W(REC_W), .LATCH_MIN(LATCH_MIN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_act     (cs_act),
  .sync_s     (sync_s),
  .sclk_fall  (sclk_fall),
  .latch_fire (latch_fire),
  .rot_flag   (rot_flag),
  .bit_cnt    (bit_cnt),
  .sdo        (sdo)
);

// File: tb/rec_readout_port_bench.sv
module rec_readout_port_bench;
  localparam int CLK_P = 10;
  localparam int NREC  = 8;
  localparam int REC_W = 32;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sync_in = 1'b0;
  logic sclk = 1'b0;
  logic precharge = 1'b0;
  logic [NREC*REC_W-1:0] rec_flat = '0;
  logic sdo;
  int errors = 0;
  int checks = 0;

  rec_readout_port #(.NREC(NREC), .REC_W(REC_W), .LATCH_MIN(2)) u_rec_readout_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sync_in   (sync_in),
    .sclk      (sclk),
    .precharge (precharge),
    .rec_data  (rec_flat),
    .sdo       (sdo)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] rec_val(int i, int seed);
    return 32'((i + 1) * 32'h1111_1111) ^ 32'(seed * 32'h0135_79BD);
  endfunction

  function automatic logic [31:0] exp_rec(int slot, bit rot, int seed);
    int r;
    r = slot;
    if (rot) r = (slot >= NREC/2) ? slot - NREC/2 : slot + NREC/2;
    return rec_val(r, seed);
  endfunction

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int seed);
    for (int i = 0; i < NREC; i++) rec_flat[i*REC_W +: REC_W] = rec_val(i, seed);
  endtask

  task automatic sync_pulse(int n);
    sync_in = 1'b1;
    waitc(n);
    sync_in = 1'b0;
    waitc(HALF);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    waitc(HALF);
  endtask

  task automatic cs_off();
    cs_n = 1'b1;
    waitc(HALF);
  endtask

  task automatic clock_bits(int n);
    for (int b = 0; b < n; b++) begin
      sclk = 1'b1; waitc(HALF);
      sclk = 1'b0; waitc(HALF);
    end
  endtask

  task automatic read_word(output logic [31:0] w);
    w = '0;
    for (int k = 0; k < 32; k++) begin
      w[8*(k/8) + 7 - (k%8)] = sdo;
      sclk = 1'b1; waitc(HALF);
      sclk = 1'b0; waitc(HALF);
    end
  endtask

  task automatic read_all(int seed, bit rot, string req);
    logic [31:0] w;
    cs_on();
    sync_pulse(2);
    for (int s = 0; s < NREC; s++) begin
      read_word(w);
      chk(w == exp_rec(s, rot, seed), req, w, exp_rec(s, rot, seed));
    end
    read_word(w);
    chk(w == 32'h0, "R9 tail zeros", w, 32'h0);
    cs_off();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] w;
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    chk(sdo == 1'b0, "R11 sdo after reset", 32'(sdo), 32'h0);

    // R11: latches empty before any latch pulse
    load(1);
    cs_on(); sync_pulse(2); read_word(w);
    chk(w == 32'h0, "R11 latches clear", w, 32'h0);
    cs_off();

    // R1 R4 R5 R6 R7: latch and full read in default order
    sync_pulse(3);
    read_all(1, 1'b0, "R1 R5 R6 R7 default order");

    // R2: pulse of exactly LATCH_MIN cycles is ignored
    load(2);
    sync_pulse(2);
    read_all(1, 1'b0, "R2 short pulse ignored");
    sync_pulse(3);
    read_all(2, 1'b0, "R2 minimum accepted pulse");

    // R8: precharge rotates one transaction only
    precharge = 1'b1; waitc(1); precharge = 1'b0; waitc(HALF);
    read_all(2, 1'b1, "R8 rotated order");
    read_all(2, 1'b0, "R8 rotation cleared");

    // R3: long sync during active transfer does not re-latch
    load(3);
    cs_on(); sync_pulse(6); read_word(w);
    chk(w == rec_val(0, 2), "R3 no relatch while active", w, rec_val(0, 2));
    cs_off();

    // R3: mid-record pointer reset
    cs_on(); sync_pulse(2); clock_bits(10); sync_pulse(2); read_word(w);
    chk(w == rec_val(0, 2), "R3 pointer reset mid record", w, rec_val(0, 2));
    read_word(w);
    chk(w == rec_val(1, 2), "R4 back to back records", w, rec_val(1, 2));
    cs_off();

    // R10: abort mid transfer
    cs_on(); sync_pulse(2); read_word(w); clock_bits(5);
    cs_n = 1'b1; waitc(HALF);
    chk(sdo == 1'b0, "R10 sdo idle after abort", 32'(sdo), 32'h0);
    cs_on(); read_word(w);
    chk(w == rec_val(0, 2), "R10 restart from first bit", w, rec_val(0, 2));
    cs_off();

    // R1 R3: latch pulse held into the active phase
    cs_n = 1'b1; sync_in = 1'b1; waitc(5);
    cs_n = 1'b0; waitc(HALF);
    sync_in = 1'b0; waitc(HALF);
    read_word(w);
    chk(w == rec_val(0, 3), "R3 held pulse resets pointer", w, rec_val(0, 3));
    read_word(w);
    chk(w == rec_val(1, 3), "R1 held pulse latched all", w, rec_val(1, 3));
    cs_off();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule